// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character at a time into a serial frame on a single output line. The frame layout is chosen at run time from an 8-bit control word and one extra size bit. The control word sets the operating mode, the parity scheme, the number of stop bits and part of the character size. A frame is a low start bit, then 5 to 9 data bits least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

Two timing sources can pace the bits. In asynchronous mode an external one-cycle bit-rate tick moves the frame forward one bit per tick. In synchronous mode a shared serial clock is brought into the core clock domain, and the line changes on the edge of that clock that the polarity bit selects. The host loads the control word through a write strobe and hands characters over with a valid/ready handshake. The ninth data bit has its own input. The frame format is captured when a character is accepted, so control writes made during a frame apply only to later frames.

Top module: `frame_tx`

## Requirements
- R1: After reset the control word is 0x06 and the extra size bit is 0. That setting means asynchronous mode, no parity, one stop bit and 8 data bits. The line `tx` is high and `in_ready` is high.
- R2: A frame is a start bit of 0, then the data bits least significant bit first, then the stop bits of 1. In asynchronous mode (control bits [7:6] = 00) each clock edge at which `baud_tick` is sampled high puts the next frame bit on `tx` at that same edge. The first such edge after acceptance drives the start bit. `tx` holds its value between ticks.
- R3: `in_ready` is high only while no frame is in progress. A character is taken at a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low from the next cycle. `in_ready` goes high again at the bit strobe that follows the strobe that drove the last stop bit. `tx` stays high at that strobe.
- R4: The data bit count comes from the 3-bit code {`cfg_wsize_hi`, control bits [2:1]}: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. Data bit 8 is taken from `in_bit8`.
- R5: Control bits [5:4] = 10 add an even parity bit and 11 add an odd parity bit. The bit is computed over the transmitted data bits only and sent straight after the last data bit. Even parity makes the count of ones in the data bits plus the parity bit even; odd parity makes that count odd. 00 adds no parity bit.
- R6: Control bit 3 = 0 sends one stop bit and 1 sends two.
- R7: The reserved parity code 01 sends no parity bit. The reserved size codes 100, 101 and 110 send 8 data bits.
- R8: In synchronous mode (control bits [7:6] = 01) the bit strobe is an edge of `xck`: the rising edge when control bit 0 is 0, the falling edge when it is 1. With the default two synchronizer stages, `tx` takes the new bit at the third rising clock edge after `xck` changes and not before.
- R9: In synchronous mode the `xck` edge that was not selected does not advance the frame. In asynchronous mode control bit 0 has no effect on the frame.
- R10: Mode codes 10 and 11 in control bits [7:6] run the transmitter as in asynchronous mode, paced by `baud_tick`.
- R11: The mode, polarity and frame format are captured when a character is accepted. A control write made during a frame does not change that frame. It applies to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word and extra size bit |
| cfg_wdata | input | 8 | Control word: mode [7:6], parity [5:4], stop [3], size [2:1], polarity [0] |
| cfg_wsize_hi | input | 1 | High bit of the 3-bit character size code |
| in_valid | input | 1 | A character is offered |
| in_ready | output | 1 | The transmitter is idle and takes a character |
| in_data | input | 8 | Data bits 7 to 0 of the character |
| in_bit8 | input | 1 | Data bit 8, used for 9-bit characters |
| baud_tick | input | 1 | One-cycle bit strobe in asynchronous mode |
| xck | input | 1 | Shared serial clock for synchronous mode |
| tx | output | 1 | Serial output line, high when idle |

## Verification
In asynchronous mode the new bit is on `tx` in the same cycle that `baud_tick` is sampled, because only the output register lies between them. The bench pulses the tick for one cycle and reads `tx` at the next falling clock edge. It reads again one tick-free cycle later to show the bit is held. In synchronous mode the new bit needs two synchronizer stages plus the output register. The bench changes `xck` on a falling clock edge, reads at the second falling edge that the old bit is still there, and reads the new bit at the third. It then shows that the opposite `xck` edge leaves `tx` and `in_ready` unchanged. The return of `in_ready` is read one falling edge after the extra strobe that closes each frame. Expected frames are built arithmetically from the control word for every size, parity and stop code.

// File: rtl/frame_tx_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, control word layout and decoded frame format
// for the configurable serial frame transmitter.
// Assumes at most 9 data bits, one parity bit and two stop bits per frame.
package frame_tx_pkg;

    localparam int MAX_DATA = 9;
    localparam int MAX_STOP = 2;
    localparam int FRAME_W  = 1 + MAX_DATA + 1 + MAX_STOP;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int NB_W     = $clog2(MAX_DATA + 1);
    localparam logic [7:0] CTRL_RST = 8'h06;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'b00,
        MODE_SYNC  = 2'b01,
        MODE_RSVD  = 2'b10,
        MODE_SPI   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_e;

    typedef struct packed {
        mode_e      mode;
        par_e       par;
        logic       two_stop;
        logic [1:0] size_lo;
        logic       pol;
    } ctrl_t;

    typedef struct packed {
        logic            sync_mode;
        logic            fall_edge;
        logic            par_en;
        logic            par_odd;
        logic            two_stop;
        logic [NB_W-1:0] nbits;
    } fmt_t;

endpackage

// File: rtl/frame_tx_cfg.sv
`timescale 1ns/1ps
// Module: frame_tx_cfg
// Holds the control word and the extra size bit. It decodes them into a
// frame format: data bit count, parity enable and sense, stop count,
// clocking mode and active edge.
// Assumes reserved codes fall back to safe values: parity 01 means none,
// size 100..110 means 8 bits, and modes 10 and 11 run as asynchronous.
module frame_tx_cfg
    import frame_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       cfg_wsize_hi,
    output fmt_t       fmt
);

    ctrl_t ctrl_q;
    logic  size_hi_q;
    logic [2:0] size_code;

    // Register the control word and size bit on each host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= ctrl_t'(CTRL_RST);
            size_hi_q <= 1'b0;
        end else if (cfg_we) begin
            ctrl_q    <= ctrl_t'(cfg_wdata);
            size_hi_q <= cfg_wsize_hi;
        end
    end

    assign size_code = {size_hi_q, ctrl_q.size_lo};

    // Decode the stored fields into the frame format.
    always_comb begin
        fmt = '0;
        fmt.sync_mode = (ctrl_q.mode == MODE_SYNC);
        fmt.fall_edge = (ctrl_q.mode == MODE_SYNC) && ctrl_q.pol;
        fmt.par_en    = (ctrl_q.par == PAR_EVEN) || (ctrl_q.par == PAR_ODD);
        fmt.par_odd   = (ctrl_q.par == PAR_ODD);
        fmt.two_stop  = ctrl_q.two_stop;
        case (size_code)
            3'b000:  fmt.nbits = NB_W'(5);
            3'b001:  fmt.nbits = NB_W'(6);
            3'b010:  fmt.nbits = NB_W'(7);
            3'b011:  fmt.nbits = NB_W'(8);
            3'b111:  fmt.nbits = NB_W'(9);
            default: fmt.nbits = NB_W'(8);
        endcase
    end

endmodule

// File: rtl/frame_tx_strobe.sv
`timescale 1ns/1ps
// Module: frame_tx_strobe
// Produces the one-cycle bit strobe. In asynchronous mode the strobe is the
// bit-rate tick. In synchronous mode it is the selected edge of the serial
// clock, detected after a synchronizer chain.
// Assumes xck is slow against clk: each level lasts at least two clk cycles.
module frame_tx_strobe #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic xck,
    input  logic sync_sel,
    input  logic fall_sel,
    output logic bit_stb
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic xck_now;
    logic xck_old;
    logic edge_hit;

    // Shift xck through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], xck};
    end

    assign xck_now = chain_q[CHAIN_W-2];
    assign xck_old = chain_q[CHAIN_W-1];

    // Select the edge that advances the frame.
    generate
        if (SYNC_STAGES >= 2) begin : g_edge
            always_comb edge_hit = fall_sel ? (xck_old & ~xck_now)
                                            : (~xck_old & xck_now);
        end else begin : g_edge_min
            always_comb edge_hit = fall_sel ? (xck_old & ~xck_now)
                                            : (~xck_old & xck_now);
        end
    endgenerate

    // Pick the pacing source for the active mode.
    always_comb bit_stb = sync_sel ? edge_hit : baud_tick;

endmodule

// File: rtl/frame_tx_build.sv
`timescale 1ns/1ps
// Module: frame_tx_build
// Lays out one frame as a bit vector, bit 0 first on the line: start bit,
// data bits least significant first, optional parity, stop bits. It also
// gives the frame length. All positions past the parity bit are 1, so
// they form the stop bits.
// Assumes nbits lies between 5 and 9.
module frame_tx_build
    import frame_tx_pkg::*;
(
    input  logic [MAX_DATA-1:0] data,
    input  logic [NB_W-1:0]     nbits,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    output logic [FRAME_W-1:0]  frame,
    output logic [CNT_W-1:0]    len
);

    logic par_acc;

    // Place the start, data and parity bits and accumulate the parity.
    always_comb begin
        frame   = '1;
        frame[0] = 1'b0;
        par_acc = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(nbits)) begin
                frame[1+i] = data[i];
                par_acc    = par_acc ^ data[i];
            end
        end
        for (int j = 1; j < FRAME_W; j++) begin
            if (par_en && (j == int'(nbits) + 1)) frame[j] = par_acc ^ par_odd;
        end
    end

    // Count the bits: start, data, parity, stops.
    always_comb begin
        len = CNT_W'(2) + CNT_W'(nbits) + CNT_W'(par_en) + CNT_W'(two_stop);
    end

endmodule

// File: rtl/frame_tx_shift.sv
`timescale 1ns/1ps
// Module: frame_tx_shift
// Sends the loaded frame. It captures the frame, its length and the pacing
// mode on start, then drives one bit per strobe. One more strobe after the
// last bit returns it to idle.
// Assumes start is asserted only while idle.
module frame_tx_shift
    import frame_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [CNT_W-1:0]   len_in,
    input  logic               sync_in,
    input  logic               fall_in,
    input  logic               bit_stb,
    output logic               busy,
    output logic               tx,
    output logic               act_sync,
    output logic               act_fall
);

    typedef enum logic {ST_IDLE, ST_SEND} st_e;

    st_e                st_q;
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               tx_q;
    logic               act_sync_q;
    logic               act_fall_q;

    // Load a frame, then move it onto the line one bit per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            sh_q       <= '1;
            cnt_q      <= '0;
            tx_q       <= 1'b1;
            act_sync_q <= 1'b0;
            act_fall_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q       <= ST_SEND;
                        sh_q       <= frame_in;
                        cnt_q      <= len_in;
                        act_sync_q <= sync_in;
                        act_fall_q <= fall_in;
                    end
                end
                ST_SEND: begin
                    if (bit_stb) begin
                        if (cnt_q != '0) begin
                            tx_q  <= sh_q[0];
                            sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
                            cnt_q <= cnt_q - CNT_W'(1);
                        end else begin
                            tx_q <= 1'b1;
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st_q == ST_SEND);
    assign tx       = tx_q;
    assign act_sync = act_sync_q;
    assign act_fall = act_fall_q;

endmodule

// File: rtl/frame_tx.sv
`timescale 1ns/1ps
// Module: frame_tx (top)
// Configurable serial frame transmitter. It joins the control register, the
// frame layout, the bit strobe source and the output shifter.
// Assumes baud_tick lasts one clk cycle and xck is slower than clk / 4.
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       cfg_wsize_hi,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_bit8,
    input  logic       baud_tick,
    input  logic       xck,
    output logic       tx
);

    fmt_t               fmt;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len;
    logic               bit_stb;
    logic               busy;
    logic               accept;
    logic               act_sync;
    logic               act_fall;

    frame_tx_cfg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_wsize_hi (cfg_wsize_hi),
        .fmt          (fmt)
    );

    frame_tx_build u_build (
        .data     ({in_bit8, in_data}),
        .nbits    (fmt.nbits),
        .par_en   (fmt.par_en),
        .par_odd  (fmt.par_odd),
        .two_stop (fmt.two_stop),
        .frame    (frame),
        .len      (len)
    );

    frame_tx_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .xck       (xck),
        .sync_sel  (act_sync),
        .fall_sel  (act_fall),
        .bit_stb   (bit_stb)
    );

    // Accept a character only while idle.
    always_comb accept = in_valid && !busy;

    frame_tx_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .frame_in (frame),
        .len_in   (len),
        .sync_in  (fmt.sync_mode),
        .fall_in  (fmt.fall_edge),
        .bit_stb  (bit_stb),
        .busy     (busy),
        .tx       (tx),
        .act_sync (act_sync),
        .act_fall (act_fall)
    );

    assign in_ready = !busy;

endmodule

// File: rtl/frame_tx_chk.sv
`timescale 1ns/1ps
// Module: frame_tx_chk
// Checker bound to frame_tx. It checks the line, handshake and strobe
// relations over time.
module frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx,
    input logic bit_stb
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tx && in_ready));

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> $stable(tx));

    // R2
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx) |-> ($past(bit_stb) && !$past(in_ready)));

    // R3
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> ($past(bit_stb) && tx));

    // R3
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx);

endmodule

bind frame_tx frame_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx       (tx),
    .bit_stb  (bit_stb)
);

// File: tb/frame_tx_bench.sv
`timescale 1ns/1ps
// Bench for frame_tx: sweeps every size, parity and stop code, both xck
// polarities, the reserved modes and mid-frame control writes.
module frame_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cfg_wsize_hi = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_bit8 = 1'b0;
    logic       baud_tick = 1'b0;
    logic       xck = 1'b0;
    logic       tx;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    frame_tx u_frame_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_wsize_hi (cfg_wsize_hi),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_bit8      (in_bit8),
        .baud_tick    (baud_tick),
        .xck          (xck),
        .tx           (tx)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected line bits from the control word, computed arithmetically.
    task automatic build_exp(input logic [7:0] c, input logic hi, input logic [8:0] d,
                             output logic [15:0] e, output int n);
        int sz;
        int nb;
        logic p;
        sz = int'({hi, c[2:1]});
        nb = (sz < 4) ? 5 + sz : ((sz == 7) ? 9 : 8);
        e = '1;
        e[0] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < nb; i++) begin
            e[1+i] = d[i];
            p = p ^ d[i];
        end
        n = 2 + nb + int'(c[3]);
        if (c[5]) begin
            e[1+nb] = p ^ c[4];
            n = n + 1;
        end
    endtask

    task automatic write_cfg(input logic [7:0] c, input logic hi);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = c; cfg_wsize_hi = hi;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Send one character and check every line bit in its due cycle.
    task automatic run_frame(input logic [7:0] c, input logic hi, input logic [8:0] d,
                             input string tag, input bit do_wr, input bit mid_wr,
                             input logic [7:0] c2, input logic hi2);
        logic [15:0] e;
        int n;
        bit sm;
        logic prev;
        build_exp(c, hi, d, e, n);
        sm = (c[7:6] == 2'b01);
        if (do_wr) write_cfg(c, hi);
        if (sm) begin
            @(negedge clk);
            xck = c[0];
            repeat (4) @(negedge clk);
        end
        chk(tag, 16'(in_ready), 16'd1);
        @(negedge clk);
        in_valid = 1'b1; in_data = d[7:0]; in_bit8 = d[8];
        @(negedge clk);
        in_valid = 1'b0;
        chk(tag, {14'd0, in_ready, tx}, 16'b01);
        for (int i = 0; i <= n; i++) begin
            if (mid_wr && i == 2) write_cfg(c2, hi2);
            prev = (i == 0) ? 1'b1 : e[i-1];
            if (sm) begin
                @(negedge clk);
                xck = ~xck;
                repeat (2) @(negedge clk);
                chk({tag, " R8 early"}, 16'(tx), 16'(prev));
                @(negedge clk);
            end else begin
                @(negedge clk);
                baud_tick = 1'b1;
                @(negedge clk);
                baud_tick = 1'b0;
            end
            if (i < n) begin
                chk(tag, 16'(tx), 16'(e[i]));
                if (sm) begin
                    @(negedge clk);
                    xck = ~xck;
                    repeat (3) @(negedge clk);
                    chk({tag, " R9 other edge"}, {14'd0, in_ready, tx}, {14'd0, 1'b0, e[i]});
                end else begin
                    @(negedge clk);
                    chk({tag, " R2 hold"}, 16'(tx), 16'(e[i]));
                end
            end else begin
                chk({tag, " R3 ready"}, {14'd0, in_ready, tx}, 16'b11);
            end
        end
    endtask

    initial begin
        logic [8:0] d;
        string tag;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle line and ready after reset
        chk("R1 reset", {14'd0, in_ready, tx}, 16'b11);
        // R1: default format is 8 data bits, no parity, one stop bit
        run_frame(8'h06, 1'b0, 9'h0B5, "R1 default", 1'b0, 1'b0, 8'h00, 1'b0);
        // R2: basic asynchronous frame
        run_frame(8'h06, 1'b0, 9'h03C, "R2", 1'b1, 1'b0, 8'h00, 1'b0);
        // R4 R5 R6 R7: sweep of size, parity and stop codes
        for (int sz = 0; sz < 8; sz++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int k = 0; k < 2; k++) begin
                        d = 9'(sz * 37 + pm * 11 + st * 5 + 195);
                        if (k == 1) d = ~d;
                        if ((sz >= 4 && sz <= 6) || pm == 1) tag = "R7";
                        else if (pm != 0) tag = "R5";
                        else if (st != 0) tag = "R6";
                        else tag = "R4";
                        run_frame({2'b00, 2'(pm), 1'(st), 2'(sz), 1'b0}, 1'(sz >> 2), d,
                                  tag, 1'b1, 1'b0, 8'h00, 1'b0);
                    end
                end
            end
        end
        // R9: polarity bit ignored in asynchronous mode
        run_frame(8'b00_10_1_11_1, 1'b0, 9'h0C9, "R9 async pol", 1'b1, 1'b0, 8'h00, 1'b0);
        // R8 R9: synchronous mode, both polarities
        run_frame(8'b01_00_0_11_0, 1'b0, 9'h0A6, "R8 rise", 1'b1, 1'b0, 8'h00, 1'b0);
        run_frame(8'b01_11_1_00_0, 1'b0, 9'h013, "R8 rise odd", 1'b1, 1'b0, 8'h00, 1'b0);
        run_frame(8'b01_10_0_11_1, 1'b1, 9'h1E1, "R8 fall", 1'b1, 1'b0, 8'h00, 1'b0);
        run_frame(8'b01_00_1_10_1, 1'b0, 9'h055, "R8 fall 7b", 1'b1, 1'b0, 8'h00, 1'b0);
        // R10: reserved and serial-peripheral mode codes run asynchronously
        run_frame(8'b10_10_0_11_0, 1'b0, 9'h0F0, "R10 mode10", 1'b1, 1'b0, 8'h00, 1'b0);
        run_frame(8'b11_11_1_01_1, 1'b0, 9'h02D, "R10 mode11", 1'b1, 1'b0, 8'h00, 1'b0);
        // R11: a write during a frame applies only to the next frame
        run_frame(8'b00_00_0_11_0, 1'b0, 9'h0A5, "R11 during", 1'b1, 1'b1,
                  8'b00_11_1_00_0, 1'b0);
        run_frame(8'b00_11_1_00_0, 1'b0, 9'h05A, "R11 after", 1'b0, 1'b0, 8'h00, 1'b0);
        run_frame(8'b01_10_0_11_1, 1'b1, 9'h133, "R11 sync during", 1'b1, 1'b1,
                  8'b00_10_1_01_0, 1'b0);
        run_frame(8'b00_10_1_01_0, 1'b0, 9'h0E7, "R11 sync after", 1'b0, 1'b0, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got running expected done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule